// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block merges sixteen level-sensitive interrupt sources into a single interrupt output through two cascaded register banks. The first bank, the host stage, latches each source into a status word that only software can clear. It combines that word with a mask and a global enable into one summary line. The second bank, the collector stage, takes that line as bit 11 of a read-only input word. It folds the masked input into a sticky status word and raises the output while any sticky bit remains.

Each bank has its own 32-bit register port with a request, a write flag, a size code, an 8-bit byte offset, write data and combinational read data. Both stages are re-evaluated in the same clock cycle as any write that can change the result, and in any cycle where a source is high. The new state appears on the next rising clock edge. The collector only gains sticky bits during such an evaluation. Clearing its mask therefore never drops a bit that is already latched.

Top module: `irqagg_top`

## Requirements
- R1: After reset the host read-size register (offset 0x28) reads 0x02000000. Every other register in both banks reads 0, and `irq_out` is low.
- R2: A high level on source n (n = 0..15) sets host status bit (31 - n) at the next clock edge. A low level never clears that bit.
- R3: A word write to host status (0x38) clears each bit written as 1. If a source is high in the same cycle, its bit stays set.
- R4: The host summary line is active when host control (0x30) bit 31 is 1 and (host status AND host mask at 0x34) is nonzero. Evaluation copies this line into bit 11 (0x800) of the collector input word (0x5C). The other bits of that word read 0, and writes to the word are ignored.
- R5: On each evaluation the collector status (0x50) is ORed with (input AND collector mask at 0x54). Writing status clears the bits written as 1, but a bit whose masked input is still 1 is set again by the same evaluation.
- R6: `irq_out` is high exactly when collector status is nonzero, and it follows that status with no extra delay.
- R7: The collector polarity word (0x58) is stored and read back, has no effect on status or `irq_out`, and a write to it starts an evaluation.
- R8: The following are plain read/write storage: firmware segment select (0x24), read size (0x28), and the two collector route words (0x08, 0x0C). The host error-address word (0x40) reads 0, and writes to it are ignored.
- R9: An access with a size code other than 2 (2 means 32-bit) is ignored on write and reads all ones. A read of an unimplemented offset returns 0xFFFFFFFF, and a write to one is ignored.
- R10: Collector status and input change only in cycles with an evaluation. Evaluations happen on writes to host control, mask or status, on writes to collector status, mask or polarity, and in cycles where any source is high. Writing 0 to the collector mask leaves latched status bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sirq_lvl | input | 16 | Source levels, bit n is source n |
| h_req | input | 1 | Host bank access request |
| h_we | input | 1 | Host bank write when 1 |
| h_size | input | 2 | Host access size code, 2 = 32-bit |
| h_addr | input | 8 | Host bank byte offset |
| h_wdata | input | 32 | Host bank write data |
| h_rdata | output | 32 | Host bank read data |
| c_req | input | 1 | Collector bank access request |
| c_we | input | 1 | Collector bank write when 1 |
| c_size | input | 2 | Collector access size code, 2 = 32-bit |
| c_addr | input | 8 | Collector bank byte offset |
| c_wdata | input | 32 | Collector bank write data |
| c_rdata | output | 32 | Collector bank read data |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
If a latched host bit is lost or cleared wrongly, the host status read is wrong at the next access. When that bit is enabled and masked, the collector input word also shows a stale bit 11 after the next evaluation. Broken sticky logic in the collector shows up one edge after the triggering write, either as a status read that does not match or as `irq_out` at the wrong level. An error in the set-over-clear order only appears while a source stays high across a clear. The bench therefore holds a source high through a status write and reads back the result.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int unsigned REG_W     = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned SIZE_W    = 2;
  localparam int unsigned SRC_MAX   = REG_W / 2;

  localparam logic [SIZE_W-1:0] SIZE_WORD = 2'd2;

  // host stage offsets
  localparam logic [ADDR_W-1:0] H_SEG   = 8'h24;
  localparam logic [ADDR_W-1:0] H_RDSZ  = 8'h28;
  localparam logic [ADDR_W-1:0] H_CTRL  = 8'h30;
  localparam logic [ADDR_W-1:0] H_MASK  = 8'h34;
  localparam logic [ADDR_W-1:0] H_STAT  = 8'h38;
  localparam logic [ADDR_W-1:0] H_ERRA  = 8'h40;

  // collector stage offsets
  localparam logic [ADDR_W-1:0] C_RT0   = 8'h08;
  localparam logic [ADDR_W-1:0] C_RT1   = 8'h0C;
  localparam logic [ADDR_W-1:0] C_STAT  = 8'h50;
  localparam logic [ADDR_W-1:0] C_MASK  = 8'h54;
  localparam logic [ADDR_W-1:0] C_POL   = 8'h58;
  localparam logic [ADDR_W-1:0] C_INP   = 8'h5C;

  localparam logic [REG_W-1:0] RDSZ_RST = 32'h0200_0000;
  localparam int unsigned      EN_BIT   = REG_W - 1;

  // Source n maps to status bit (REG_W-1-n).
  function automatic logic [REG_W-1:0] src_to_stat(input logic [SRC_MAX-1:0] lvl);
    logic [REG_W-1:0] v;
    v = '0;
    for (int n = 0; n < SRC_MAX; n++) begin
      v[REG_W-1-n] = lvl[n];
    end
    return v;
  endfunction

  // Clear-by-one then set; a set wins over a clear of the same bit.
  function automatic logic [REG_W-1:0] w1c_merge(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] clr,
                                                 input logic [REG_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic summary_line(input logic enable,
                                        input logic [REG_W-1:0] stat,
                                        input logic [REG_W-1:0] mask);
    return enable && ((stat & mask) != '0);
  endfunction

endpackage

// File: rtl/irqagg_host_bank.sv
module irqagg_host_bank
  import irqagg_pkg::*;
#(
  parameter int unsigned N_SRC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic [N_SRC-1:0]     src_lvl,
  output logic [REG_W-1:0]     rdata,
  output logic                 line_next,
  output logic                 line_now,
  output logic                 eval_evt
);

  logic [REG_W-1:0] seg_q, rdsz_q, ctrl_q, mask_q, stat_q;
  logic [REG_W-1:0] ctrl_n, mask_n, stat_n;
  logic [SRC_MAX-1:0] lvl_pad;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic wr_seg, wr_rdsz, wr_ctrl, wr_mask, wr_stat;
  logic any_src;

  always_comb begin
    lvl_pad = '0;
    lvl_pad[N_SRC-1:0] = src_lvl;
  end

  assign set_vec = src_to_stat(lvl_pad);
  assign any_src = |src_lvl;

  assign wr_seg  = wr_stb && (addr == H_SEG);
  assign wr_rdsz = wr_stb && (addr == H_RDSZ);
  assign wr_ctrl = wr_stb && (addr == H_CTRL);
  assign wr_mask = wr_stb && (addr == H_MASK);
  assign wr_stat = wr_stb && (addr == H_STAT);

  assign clr_vec = wr_stat ? wdata : '0;

  always_comb begin
    ctrl_n = wr_ctrl ? wdata : ctrl_q;
    mask_n = wr_mask ? wdata : mask_q;
    stat_n = w1c_merge(stat_q, clr_vec, set_vec);
  end

  assign eval_evt  = wr_ctrl || wr_mask || wr_stat || any_src;
  assign line_next = summary_line(ctrl_n[EN_BIT], stat_n, mask_n);
  assign line_now  = summary_line(ctrl_q[EN_BIT], stat_q, mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q  <= '0;
      rdsz_q <= RDSZ_RST;
      ctrl_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_seg)  seg_q  <= wdata;
      if (wr_rdsz) rdsz_q <= wdata;
      ctrl_q <= ctrl_n;
      mask_q <= mask_n;
      stat_q <= stat_n;
    end
  end

  always_comb begin
    unique case (addr)
      H_SEG:   rdata = seg_q;
      H_RDSZ:  rdata = rdsz_q;
      H_CTRL:  rdata = ctrl_q;
      H_MASK:  rdata = mask_q;
      H_STAT:  rdata = stat_q;
      H_ERRA:  rdata = '0;
      default: rdata = '1;
    endcase
  end

  // R2: a high source sets its bit at the next edge
  assert_src_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R2: without a status write no latched bit is lost
  assert_no_self_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R3: bits written as one vanish when no source is high
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !any_src) |=> ((stat_q & $past(wdata)) == '0));

endmodule

// File: rtl/irqagg_coll_bank.sv
module irqagg_coll_bank
  import irqagg_pkg::*;
#(
  parameter int unsigned LINE_BIT = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 ext_eval,
  input  logic                 line_next,
  output logic [REG_W-1:0]     rdata,
  output logic                 line_seen,
  output logic                 eval_any,
  output logic                 irq_out
);

  logic [REG_W-1:0] rt0_q, rt1_q, stat_q, mask_q, pol_q, inp_q;
  logic [REG_W-1:0] inp_n, mask_n, stat_n, clr_vec, fold_vec;
  logic wr_rt0, wr_rt1, wr_stat, wr_mask, wr_pol;
  logic irq_q;

  assign wr_rt0  = wr_stb && (addr == C_RT0);
  assign wr_rt1  = wr_stb && (addr == C_RT1);
  assign wr_stat = wr_stb && (addr == C_STAT);
  assign wr_mask = wr_stb && (addr == C_MASK);
  assign wr_pol  = wr_stb && (addr == C_POL);

  // polarity write is an evaluation trigger, its value is never applied
  assign eval_any = ext_eval || wr_stat || wr_mask || wr_pol;

  always_comb begin
    inp_n = inp_q;
    if (eval_any) begin
      inp_n = '0;
      inp_n[LINE_BIT] = line_next;
    end
    mask_n   = wr_mask ? wdata : mask_q;
    clr_vec  = wr_stat ? wdata : '0;
    fold_vec = eval_any ? (inp_n & mask_n) : '0;
    stat_n   = w1c_merge(stat_q, clr_vec, fold_vec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rt0_q  <= '0;
      rt1_q  <= '0;
      stat_q <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      inp_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_rt0) rt0_q <= wdata;
      if (wr_rt1) rt1_q <= wdata;
      if (wr_pol) pol_q <= wdata;
      mask_q <= mask_n;
      inp_q  <= inp_n;
      stat_q <= stat_n;
      irq_q  <= (stat_n != '0);
    end
  end

  assign irq_out   = irq_q;
  assign line_seen = inp_q[LINE_BIT];

  always_comb begin
    unique case (addr)
      C_RT0:   rdata = rt0_q;
      C_RT1:   rdata = rt1_q;
      C_STAT:  rdata = stat_q;
      C_MASK:  rdata = mask_q;
      C_POL:   rdata = pol_q;
      C_INP:   rdata = inp_q;
      default: rdata = '1;
    endcase
  end

  // R5: sticky bits survive any cycle without a status write
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R10: without an evaluation status and input stay put
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_any |=> ($stable(stat_q) && $stable(inp_q)));

  // R6: output level agrees with the latched status
  assert_out_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (stat_q != '0));

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned N_SRC    = 16,
  parameter int unsigned LINE_BIT = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     sirq_lvl,
  input  logic                 h_req,
  input  logic                 h_we,
  input  logic [SIZE_W-1:0]    h_size,
  input  logic [ADDR_W-1:0]    h_addr,
  input  logic [REG_W-1:0]     h_wdata,
  output logic [REG_W-1:0]     h_rdata,
  input  logic                 c_req,
  input  logic                 c_we,
  input  logic [SIZE_W-1:0]    c_size,
  input  logic [ADDR_W-1:0]    c_addr,
  input  logic [REG_W-1:0]     c_wdata,
  output logic [REG_W-1:0]     c_rdata,
  output logic                 irq_out
);

  logic h_ok, c_ok, h_wr, c_wr;
  logic [REG_W-1:0] h_bank_rd, c_bank_rd;
  logic line_next, line_now, h_eval, c_eval, line_seen;

  assign h_ok = (h_size == SIZE_WORD);
  assign c_ok = (c_size == SIZE_WORD);
  assign h_wr = h_req && h_we && h_ok;
  assign c_wr = c_req && c_we && c_ok;

  irqagg_host_bank #(.N_SRC(N_SRC)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (h_wr),
    .addr      (h_addr),
    .wdata     (h_wdata),
    .src_lvl   (sirq_lvl),
    .rdata     (h_bank_rd),
    .line_next (line_next),
    .line_now  (line_now),
    .eval_evt  (h_eval)
  );

  irqagg_coll_bank #(.LINE_BIT(LINE_BIT)) u_coll (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (c_wr),
    .addr      (c_addr),
    .wdata     (c_wdata),
    .ext_eval  (h_eval),
    .line_next (line_next),
    .rdata     (c_bank_rd),
    .line_seen (line_seen),
    .eval_any  (c_eval),
    .irq_out   (irq_out)
  );

  assign h_rdata = h_ok ? h_bank_rd : '1;
  assign c_rdata = c_ok ? c_bank_rd : '1;

  // R4: after an evaluation the collector input copies the host line
  assert_line_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_eval |=> (line_seen == line_now));

endmodule

// File: tb/irqagg_top_tb.sv
module irqagg_top_tb_top;
  import irqagg_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WD_CYCLES  = 20000;

  localparam logic [2:0] OP_HW = 3'd0, OP_HR = 3'd1, OP_CW = 3'd2,
                         OP_CR = 3'd3, OP_SRC = 3'd4, OP_IRQ = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 61;
  localparam vec_t TBL [NV] = '{
    '{OP_HR, 2'd2, 8'h28, 32'h0, 32'h0200_0000, 4'd1},   // R1
    '{OP_HR, 2'd2, 8'h38, 32'h0, 32'h0, 4'd1},           // R1
    '{OP_CR, 2'd2, 8'h50, 32'h0, 32'h0, 4'd1},           // R1
    '{OP_IRQ,2'd2, 8'h00, 32'h0, 32'h0, 4'd1},           // R1
    '{OP_HW, 2'd2, 8'h24, 32'h1234_5678, 32'h0, 4'd8},   // R8
    '{OP_HR, 2'd2, 8'h24, 32'h0, 32'h1234_5678, 4'd8},   // R8
    '{OP_HW, 2'd2, 8'h40, 32'h0000_FFFF, 32'h0, 4'd8},   // R8
    '{OP_HR, 2'd2, 8'h40, 32'h0, 32'h0, 4'd8},           // R8
    '{OP_CW, 2'd2, 8'h08, 32'hA5A5_A5A5, 32'h0, 4'd8},   // R8
    '{OP_CR, 2'd2, 8'h08, 32'h0, 32'hA5A5_A5A5, 4'd8},   // R8
    '{OP_CW, 2'd2, 8'h0C, 32'h0F0F_0000, 32'h0, 4'd8},   // R8
    '{OP_CR, 2'd2, 8'h0C, 32'h0, 32'h0F0F_0000, 4'd8},   // R8
    '{OP_HR, 2'd2, 8'h10, 32'h0, 32'hFFFF_FFFF, 4'd9},   // R9
    '{OP_CR, 2'd2, 8'h60, 32'h0, 32'hFFFF_FFFF, 4'd9},   // R9
    '{OP_SRC,2'd2, 8'h00, 32'h0001, 32'h0, 4'd2},        // R2 source 0
    '{OP_SRC,2'd2, 8'h00, 32'h0000, 32'h0, 4'd2},        // R2
    '{OP_HR, 2'd2, 8'h38, 32'h0, 32'h8000_0000, 4'd2},   // R2
    '{OP_SRC,2'd2, 8'h00, 32'h8000, 32'h0, 4'd2},        // R2 source 15
    '{OP_SRC,2'd2, 8'h00, 32'h0000, 32'h0, 4'd2},        // R2
    '{OP_HR, 2'd2, 8'h38, 32'h0, 32'h8001_0000, 4'd2},   // R2
    '{OP_CR, 2'd2, 8'h5C, 32'h0, 32'h0, 4'd4},           // R4 disabled
    '{OP_HW, 2'd2, 8'h34, 32'h8000_0000, 32'h0, 4'd4},   // R4
    '{OP_CR, 2'd2, 8'h5C, 32'h0, 32'h0, 4'd4},           // R4 still disabled
    '{OP_HW, 2'd2, 8'h30, 32'h8000_0000, 32'h0, 4'd4},   // R4 enable
    '{OP_CR, 2'd2, 8'h5C, 32'h0, 32'h0000_0800, 4'd4},   // R4
    '{OP_CR, 2'd2, 8'h50, 32'h0, 32'h0, 4'd5},           // R5 mask zero
    '{OP_IRQ,2'd2, 8'h00, 32'h0, 32'h0, 4'd6},           // R6
    '{OP_CW, 2'd2, 8'h5C, 32'h0, 32'h0, 4'd4},           // R4 read-only
    '{OP_CR, 2'd2, 8'h5C, 32'h0, 32'h0000_0800, 4'd4},   // R4
    '{OP_CW, 2'd2, 8'h54, 32'h0000_0800, 32'h0, 4'd5},   // R5
    '{OP_CR, 2'd2, 8'h50, 32'h0, 32'h0000_0800, 4'd5},   // R5
    '{OP_IRQ,2'd2, 8'h00, 32'h0, 32'h1, 4'd6},           // R6
    '{OP_HW, 2'd2, 8'h38, 32'h8000_0000, 32'h0, 4'd3},   // R3
    '{OP_CR, 2'd2, 8'h5C, 32'h0, 32'h0, 4'd4},           // R4 line dropped
    '{OP_CR, 2'd2, 8'h50, 32'h0, 32'h0000_0800, 4'd5},   // R5 sticky
    '{OP_HR, 2'd2, 8'h38, 32'h0, 32'h0001_0000, 4'd3},   // R3
    '{OP_CW, 2'd2, 8'h50, 32'h0000_0800, 32'h0, 4'd5},   // R5 clear
    '{OP_CR, 2'd2, 8'h50, 32'h0, 32'h0, 4'd5},           // R5
    '{OP_IRQ,2'd2, 8'h00, 32'h0, 32'h0, 4'd6},           // R6
    '{OP_CW, 2'd2, 8'h58, 32'hFFFF_FFFF, 32'h0, 4'd7},   // R7
    '{OP_CR, 2'd2, 8'h58, 32'h0, 32'hFFFF_FFFF, 4'd7},   // R7
    '{OP_CR, 2'd2, 8'h50, 32'h0, 32'h0, 4'd7},           // R7
    '{OP_IRQ,2'd2, 8'h00, 32'h0, 32'h0, 4'd7},           // R7
    '{OP_HW, 2'd2, 8'h34, 32'h0001_0000, 32'h0, 4'd4},   // R4 line on
    '{OP_IRQ,2'd2, 8'h00, 32'h0, 32'h1, 4'd6},           // R6
    '{OP_CW, 2'd2, 8'h50, 32'h0000_0800, 32'h0, 4'd5},   // R5 clear vs live
    '{OP_CR, 2'd2, 8'h50, 32'h0, 32'h0000_0800, 4'd5},   // R5 re-set
    '{OP_CW, 2'd2, 8'h54, 32'h0, 32'h0, 4'd10},          // R10
    '{OP_CR, 2'd2, 8'h50, 32'h0, 32'h0000_0800, 4'd10},  // R10 kept
    '{OP_CW, 2'd2, 8'h50, 32'h0000_0800, 32'h0, 4'd5},   // R5
    '{OP_CR, 2'd2, 8'h50, 32'h0, 32'h0, 4'd5},           // R5
    '{OP_IRQ,2'd2, 8'h00, 32'h0, 32'h0, 4'd6},           // R6
    '{OP_HW, 2'd0, 8'h24, 32'hDEAD_BEEF, 32'h0, 4'd9},   // R9 byte write
    '{OP_HR, 2'd2, 8'h24, 32'h0, 32'h1234_5678, 4'd9},   // R9
    '{OP_HR, 2'd1, 8'h24, 32'h0, 32'hFFFF_FFFF, 4'd9},   // R9 half read
    '{OP_SRC,2'd2, 8'h00, 32'h0002, 32'h0, 4'd3},        // R3 hold source 1
    '{OP_HW, 2'd2, 8'h38, 32'h4000_0000, 32'h0, 4'd3},   // R3
    '{OP_HR, 2'd2, 8'h38, 32'h0, 32'h4001_0000, 4'd3},   // R3 set wins
    '{OP_SRC,2'd2, 8'h00, 32'h0000, 32'h0, 4'd3},        // R3
    '{OP_HW, 2'd2, 8'h38, 32'hFFFF_FFFF, 32'h0, 4'd3},   // R3
    '{OP_HR, 2'd2, 8'h38, 32'h0, 32'h0, 4'd3}            // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sirq_lvl = '0;
  logic        h_req = 1'b0, h_we = 1'b0, c_req = 1'b0, c_we = 1'b0;
  logic [1:0]  h_size = 2'd2, c_size = 2'd2;
  logic [7:0]  h_addr = '0, c_addr = '0;
  logic [31:0] h_wdata = '0, c_wdata = '0;
  logic [31:0] h_rdata, c_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqagg_top dut_i (
    .clk(clk), .rst_n(rst_n), .sirq_lvl(sirq_lvl),
    .h_req(h_req), .h_we(h_we), .h_size(h_size), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata),
    .c_req(c_req), .c_we(c_we), .c_size(c_size), .c_addr(c_addr),
    .c_wdata(c_wdata), .c_rdata(c_rdata), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [1:0] sz,
                        input logic [7:0] addr, input logic [31:0] data,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0; c_req = 1'b0; c_we = 1'b0;
    h_size = sz; c_size = sz;
    case (op)
      OP_HW: begin h_req = 1'b1; h_we = 1'b1; h_addr = addr; h_wdata = data; end
      OP_HR: begin h_req = 1'b1; h_addr = addr; end
      OP_CW: begin c_req = 1'b1; c_we = 1'b1; c_addr = addr; c_wdata = data; end
      OP_CR: begin c_req = 1'b1; c_addr = addr; end
      OP_SRC: sirq_lvl = data[15:0];
      default: ;
    endcase
    #(CLK_PERIOD/4);
    case (op)
      OP_HR:  check(tag, h_rdata, exp);
      OP_CR:  check(tag, c_rdata, exp);
      OP_IRQ: check(tag, {31'b0, irq_out}, exp);
      default: ;
    endcase
  endtask

  task automatic idle();
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0; c_req = 1'b0; c_we = 1'b0;
    h_size = 2'd2; c_size = 2'd2;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(TBL[i].op, TBL[i].sz, TBL[i].addr, TBL[i].data, TBL[i].exp,
             $sformatf("R%0d step %0d", TBL[i].req, i));
    end
    idle();

    // R2: all sources high at once
    run_op(OP_SRC, 2'd2, 8'h00, 32'hFFFF, 32'h0, "R2");
    run_op(OP_SRC, 2'd2, 8'h00, 32'h0000, 32'h0, "R2");
    run_op(OP_HR, 2'd2, 8'h38, 32'h0, 32'hFFFF_0000, "R2 all sources");

    // R5: wide collector mask only latches the line bit
    run_op(OP_CW, 2'd2, 8'h54, 32'hFFFF_FFFF, 32'h0, "R5");
    run_op(OP_CR, 2'd2, 8'h50, 32'h0, 32'h0000_0800, "R5 wide mask");
    run_op(OP_IRQ, 2'd2, 8'h00, 32'h0, 32'h1, "R6 raised");

    // R4: disabling the host drops the line but not the sticky bit
    run_op(OP_HW, 2'd2, 8'h30, 32'h0, 32'h0, "R4");
    run_op(OP_CR, 2'd2, 8'h5C, 32'h0, 32'h0, "R4 disabled line");
    run_op(OP_CR, 2'd2, 8'h50, 32'h0, 32'h0000_0800, "R5 sticky after disable");
    idle();

    // R1: reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_op(OP_HR, 2'd2, 8'h24, 32'h0, 32'h0, "R1 seg after reset");
    run_op(OP_HR, 2'd2, 8'h28, 32'h0, 32'h0200_0000, "R1 size after reset");
    run_op(OP_HR, 2'd2, 8'h38, 32'h0, 32'h0, "R1 host status after reset");
    run_op(OP_CR, 2'd2, 8'h54, 32'h0, 32'h0, "R1 mask after reset");
    run_op(OP_CR, 2'd2, 8'h50, 32'h0, 32'h0, "R1 coll status after reset");
    run_op(OP_IRQ, 2'd2, 8'h00, 32'h0, 32'h0, "R1 irq after reset");
    idle();

    finish_run();
  end

endmodule